// File: doc/BRIEF.md
# Device Power-State Startup Sequencer

This block brings a bus-attached network device from power-off to full operation. When power becomes good it moves to a state where it waits for the bus reset to be released, and it fetches configuration from an external EEPROM reader. That first fetch decides whether wake-up is enabled. When the active-low bus reset is released, the block clears wake enable, starts a second fetch and enters an active-but-uninitialized state. It then waits a fixed settling window before it lets the device drive the bus. A command-register write from software that sets the memory-access or I/O-access bit finishes the startup and moves the block to the fully active state.

Power-good acts as the block's synchronous active-high reset, inverted: while it is low, every register returns to its power-off value. The EEPROM serial protocol, bus transactions and wake packet detection are handled elsewhere. This block only raises a request and waits for a completion pulse.

Top module: `pwr_startup_seq`

## Requirements
- R1: The state code on `pstate` is 2'b00 off, 2'b01 reset-held, 2'b10 uninitialized-active and 2'b11 fully active. On any clock edge where `pwr_good` is low, the next values are `pstate`=00 with `ee_req`, `wake_en`, `bus_drive_en` and `pwr_ind` all zero, whatever the previous state.
- R2: In the off state with `pwr_good` high, the next clock gives `pstate`=01 and raises `ee_req` for the power-up configuration load.
- R3: `ee_req` stays high until a clock edge samples `ee_done` high, and it is low after that edge. An `ee_done` pulse while `ee_req` is low changes no output.
- R4: The edge that completes the power-up load sets `wake_en` to the value of `ee_apm_bit` sampled at that edge.
- R5: While `bus_rst_n` is low in the reset-held state, `pstate` stays 01 with no time limit.
- R6: In the reset-held state, with `bus_rst_n` high and no load outstanding, the next clock gives `pstate`=10, `wake_en`=0 and a new `ee_req` for the release load. The `ee_apm_bit` value returned by this load has no effect on `wake_en`.
- R7: `bus_drive_en` is low on the first 511 clock edges after the edge that completes the release load, and high after the 512th. The window is timed by a 10-bit counter.
- R8: In the uninitialized state, with `bus_drive_en` high, a `cmd_wr` with `cmd_mem_en` or `cmd_io_en` set gives `pstate`=11 and `pwr_ind`=2'b11 on the next clock.
- R9: A `cmd_wr` with neither access bit set leaves `pstate` unchanged. So does a `cmd_wr` sent before `bus_drive_en` is high, or sent in any state other than uninitialized.
- R10: `bus_rst_n` low in state 10 or 11 gives `pstate`=01 on the next clock, with `bus_drive_en` and `pwr_ind` zero. The next release starts a new release load and a full new settling window. No power-up load is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwr_good | input | 1 | Supplies and clock stable; low acts as synchronous reset |
| bus_rst_n | input | 1 | Active-low bus reset |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_mem_en | input | 1 | Memory-access enable bit of the write |
| cmd_io_en | input | 1 | I/O-access enable bit of the write |
| ee_req | output | 1 | Request to the EEPROM reader, held until done |
| ee_done | input | 1 | One-cycle completion from the EEPROM reader |
| ee_apm_bit | input | 1 | Wake configuration bit returned with the completion |
| pstate | output | 2 | Current power-state code |
| wake_en | output | 1 | Wake-up enable flag |
| bus_drive_en | output | 1 | Permission to drive the bus and answer transactions |
| pwr_ind | output | 2 | Power-state indicator pins, both high when fully active |

## Verification
Several power-up cycles run with random EEPROM latencies, random wake bits and random reset hold times, one of them thousands of cycles long. These show that the wake flag follows only the first load, and that the reset-held state never times out. The settling window is measured edge by edge after each release load, including a window restarted by a reset reassertion. This separates an exact 512-clock wait from off-by-one variants. Command writes are sent with the memory bit, the I/O bit, no bit, during settling and in the fully active state. This tells an accepted access enable apart from a write that must be ignored. The run ends either by reasserting reset or by dropping power, so both ways of leaving the active state are covered.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [1:0] {
    PS_OFF      = 2'b00,
    PS_RSTHOLD  = 2'b01,
    PS_UNINIT   = 2'b10,
    PS_ACTIVE   = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'b00,
    PH_SETTLE = 2'b01,
    PH_READY  = 2'b10
  } phase_e;

  typedef enum logic {
    LK_POWER   = 1'b0,
    LK_RELEASE = 1'b1
  } load_kind_e;

  localparam logic [1:0] IND_ON  = 2'b11;
  localparam logic [1:0] IND_OFF = 2'b00;

endpackage

// File: rtl/pseq_ee_loader.sv
module pseq_ee_loader
  import pseq_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       start,
  input  load_kind_e kind_in,
  input  logic       ee_done,
  output logic       ee_req,
  output logic       busy,
  output logic       done_power,
  output logic       done_release
);

  load_kind_e kind_q;
  logic       finish;

  assign finish       = ee_req && ee_done;
  assign busy         = ee_req;
  assign done_power   = finish && (kind_q == LK_POWER);
  assign done_release = finish && (kind_q == LK_RELEASE);

  always_ff @(posedge clk) begin
    if (srst) begin
      ee_req <= 1'b0;
      kind_q <= LK_POWER;
    end else if (finish) begin
      ee_req <= 1'b0;
    end else if (start) begin
      ee_req <= 1'b1;
      kind_q <= kind_in;
    end
  end

  // R3: an open request is held until the reader answers
  a_r3_req_held: assert property (@(posedge clk) disable iff (srst)
    ee_req && !ee_done |=> ee_req);

  // R3: the sequencer never starts a load while one is outstanding
  a_r3_start_when_idle: assert property (@(posedge clk) disable iff (srst)
    start |-> !ee_req);

endmodule

// File: rtl/pseq_settle_timer.sv
module pseq_settle_timer #(
  parameter int SETTLE_CLKS = 512
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic hit
);

  localparam int CNT_W = $clog2(SETTLE_CLKS) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (run && !hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: the count never runs past the last cycle of the window
  a_r7_count_bound: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST);

endmodule

// File: rtl/pwr_startup_seq.sv
module pwr_startup_seq
  import pseq_pkg::*;
#(
  parameter int SETTLE_CLKS = 512
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       bus_rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_mem_en,
  input  logic       cmd_io_en,
  output logic       ee_req,
  input  logic       ee_done,
  input  logic       ee_apm_bit,
  output logic [1:0] pstate,
  output logic       wake_en,
  output logic       bus_drive_en,
  output logic [1:0] pwr_ind
);

  logic       srst;
  pstate_e    state_q;
  phase_e     phase_q;
  logic       ld_busy, ld_done_pwr, ld_done_rel, ld_start;
  load_kind_e ld_kind;
  logic       start_pwr, start_rel, access_req;
  logic       tmr_run, tmr_clr, tmr_hit;

  assign srst       = !pwr_good;
  assign start_pwr  = (state_q == PS_OFF);
  assign start_rel  = (state_q == PS_RSTHOLD) && bus_rst_n && !ld_busy;
  assign ld_start   = start_pwr || start_rel;
  assign ld_kind    = start_rel ? LK_RELEASE : LK_POWER;
  assign access_req = cmd_wr && (cmd_mem_en || cmd_io_en);
  assign tmr_run    = (state_q == PS_UNINIT) && (phase_q == PH_SETTLE);
  assign tmr_clr    = srst || !tmr_run;

  pseq_ee_loader u_loader (
    .clk          (clk),
    .srst         (srst),
    .start        (ld_start),
    .kind_in      (ld_kind),
    .ee_done      (ee_done),
    .ee_req       (ee_req),
    .busy         (ld_busy),
    .done_power   (ld_done_pwr),
    .done_release (ld_done_rel)
  );

  pseq_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
    .clk (clk),
    .clr (tmr_clr),
    .run (tmr_run),
    .hit (tmr_hit)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q      <= PS_OFF;
      phase_q      <= PH_LOAD;
      wake_en      <= 1'b0;
      bus_drive_en <= 1'b0;
      pwr_ind      <= IND_OFF;
    end else begin
      case (state_q)
        PS_OFF: begin
          state_q <= PS_RSTHOLD;
        end
        PS_RSTHOLD: begin
          if (ld_done_pwr) wake_en <= ee_apm_bit;
          if (start_rel) begin
            state_q <= PS_UNINIT;
            phase_q <= PH_LOAD;
            wake_en <= 1'b0;
          end
        end
        PS_UNINIT: begin
          if (!bus_rst_n) begin
            state_q      <= PS_RSTHOLD;
            phase_q      <= PH_LOAD;
            bus_drive_en <= 1'b0;
          end else begin
            case (phase_q)
              PH_LOAD:   if (ld_done_rel) phase_q <= PH_SETTLE;
              PH_SETTLE: if (tmr_hit) begin
                phase_q      <= PH_READY;
                bus_drive_en <= 1'b1;
              end
              PH_READY:  if (access_req) begin
                state_q <= PS_ACTIVE;
                pwr_ind <= IND_ON;
              end
              default:   phase_q <= PH_LOAD;
            endcase
          end
        end
        PS_ACTIVE: begin
          if (!bus_rst_n) begin
            state_q      <= PS_RSTHOLD;
            phase_q      <= PH_LOAD;
            bus_drive_en <= 1'b0;
            pwr_ind      <= IND_OFF;
          end
        end
        default: state_q <= PS_OFF;
      endcase
    end
  end

  assign pstate = state_q;

  // R2: leaving off always opens the power-up load
  a_r2_power_load: assert property (@(posedge clk) disable iff (srst)
    pstate == PS_OFF |=> ee_req && pstate == PS_RSTHOLD);

  // R5: held reset keeps the reset-held state
  a_r5_hold_in_reset: assert property (@(posedge clk) disable iff (srst)
    pstate == PS_RSTHOLD && !bus_rst_n |=> pstate == PS_RSTHOLD);

  // R6: wake stays cleared once the reset has been released
  a_r6_wake_low_after_release: assert property (@(posedge clk) disable iff (srst)
    pstate[1] |-> !wake_en);

  // R7: bus driving only in the two active states
  a_r7_drive_only_active: assert property (@(posedge clk) disable iff (srst)
    bus_drive_en |-> pstate[1]);

  // R8: indicator pins both high exactly when fully active
  a_r8_ind_active: assert property (@(posedge clk) disable iff (srst)
    (pstate == PS_ACTIVE) == (pwr_ind == IND_ON));

  // R9: the fully active state ignores command writes
  a_r9_active_sticky: assert property (@(posedge clk) disable iff (srst)
    pstate == PS_ACTIVE && bus_rst_n |=> pstate == PS_ACTIVE);

  // R10: reset reassertion drops back to the reset-held state
  a_r10_reassert: assert property (@(posedge clk) disable iff (srst)
    pstate[1] && !bus_rst_n |=> pstate == PS_RSTHOLD && !bus_drive_en);

endmodule

// File: tb/tb_pwr_startup_seq.sv
module tb_pwr_startup_seq;

  localparam int SETTLE = 512;

  logic       clk = 1'b0;
  logic       pwr_good, bus_rst_n, cmd_wr, cmd_mem_en, cmd_io_en;
  logic       ee_done, ee_apm_bit;
  logic       ee_req, wake_en, bus_drive_en;
  logic [1:0] pstate, pwr_ind;

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;

  always #10 clk = ~clk;

  pwr_startup_seq #(.SETTLE_CLKS(SETTLE)) dut (
    .clk(clk), .pwr_good(pwr_good), .bus_rst_n(bus_rst_n),
    .cmd_wr(cmd_wr), .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en),
    .ee_req(ee_req), .ee_done(ee_done), .ee_apm_bit(ee_apm_bit),
    .pstate(pstate), .wake_en(wake_en), .bus_drive_en(bus_drive_en),
    .pwr_ind(pwr_ind)
  );

  function automatic int exp_ind(input int st);
    return (st == 3) ? 3 : 0;
  endfunction

  function automatic int exp_drive(input int st, input bit settled);
    return (st >= 2 && settled) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic serve(input bit apm, input string req);
    int d;
    d = int'($urandom_range(0, 5));
    repeat (d) begin
      @(negedge clk);
      check(req, int'(ee_req), 1);
    end
    ee_done = 1'b1;
    ee_apm_bit = apm;
    @(negedge clk);
    ee_done = 1'b0;
    check(req, int'(ee_req), 0);
  endtask

  task automatic wait_settle(input bit inject);
    for (int i = 1; i < SETTLE; i++) begin
      @(negedge clk);
      cmd_wr = 1'b0;
      cmd_mem_en = 1'b0;
      if (inject && i == 100) begin
        cmd_wr = 1'b1;
        cmd_mem_en = 1'b1;
      end
      if (inject && i == 101) check("R9 write before settle", int'(pstate), 2);
    end
    check("R7 low at 511", int'(bus_drive_en), exp_drive(2, 1'b0));
    @(negedge clk);
    check("R7 high at 512", int'(bus_drive_en), exp_drive(2, 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    int h;
    void'($urandom(32'd4242));
    pwr_good = 0; bus_rst_n = 0; cmd_wr = 0; cmd_mem_en = 0; cmd_io_en = 0;
    ee_done = 0; ee_apm_bit = 0;
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(pstate), 0);
    check("R1 reset req", int'(ee_req), 0);
    check("R1 reset drive", int'(bus_drive_en), 0);
    check("R1 reset ind", int'(pwr_ind), 0);

    for (int k = 0; k < 4; k++) begin
      a = (k == 0) ? 1'b1 : 1'(($urandom() >> 3) & 1);
      pwr_good = 1'b1;
      @(negedge clk);
      check("R2 state", int'(pstate), 1);
      check("R2 req", int'(ee_req), 1);
      serve(a, "R3 power load");
      check("R4 wake", int'(wake_en), int'(a));
      // stray completion while idle
      ee_done = 1'b1; ee_apm_bit = ~a;
      @(negedge clk);
      ee_done = 1'b0;
      check("R3 stray done wake", int'(wake_en), int'(a));
      check("R3 stray done req", int'(ee_req), 0);
      h = (k == 0) ? 2000 : int'($urandom_range(1, 40));
      repeat (h) @(negedge clk);
      check("R5 held", int'(pstate), 1);
      bus_rst_n = 1'b1;
      @(negedge clk);
      check("R6 state", int'(pstate), 2);
      check("R6 wake cleared", int'(wake_en), 0);
      check("R6 req", int'(ee_req), 1);
      serve(1'b1, "R3 release load");
      check("R6 apm ignored", int'(wake_en), 0);
      wait_settle(k == 1);
      cmd_wr = 1'b1; cmd_mem_en = 1'b0; cmd_io_en = 1'b0;
      @(negedge clk);
      check("R9 no access bit", int'(pstate), 2);
      cmd_mem_en = (k % 2 == 0); cmd_io_en = (k % 2 == 1);
      @(negedge clk);
      cmd_wr = 1'b0; cmd_mem_en = 1'b0; cmd_io_en = 1'b0;
      check("R8 active", int'(pstate), 3);
      check("R8 ind", int'(pwr_ind), exp_ind(3));
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      check("R9 write in active", int'(pstate), 3);
      if (k % 2 == 0) begin
        bus_rst_n = 1'b0;
        @(negedge clk);
        check("R10 state", int'(pstate), 1);
        check("R10 drive", int'(bus_drive_en), 0);
        check("R10 ind", int'(pwr_ind), exp_ind(1));
        check("R10 no power load", int'(ee_req), 0);
        repeat (3) @(negedge clk);
        bus_rst_n = 1'b1;
        @(negedge clk);
        check("R10 release state", int'(pstate), 2);
        check("R10 release req", int'(ee_req), 1);
        serve(1'b0, "R3 second release load");
        wait_settle(1'b0);
      end
      pwr_good = 1'b0;
      bus_rst_n = 1'b0;
      @(negedge clk);
      check("R1 power loss state", int'(pstate), 0);
      check("R1 power loss drive", int'(bus_drive_en), 0);
      check("R1 power loss ind", int'(pwr_ind), 0);
      check("R1 power loss wake", int'(wake_en), 0);
      repeat (2) @(negedge clk);
    end

    if (!summary_done) begin
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule